// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller behind an 8-bit successive-approximation converter with a four-way analog input selector. The selector, sample-and-hold, reference DAC and comparator are outside the block. The block drives the selector code and a one-cycle hold strobe, then runs a binary search. In the search it drives a trial code to the DAC, reads back one comparator bit per clock, and keeps or drops each trial bit from that answer. The finished code goes into a result slot owned by the converted channel.

A small sequencer picks the channels to convert. It can convert one fixed channel once or repeatedly. It can sweep every enabled channel in ascending order, once or without end. It can alternate between two chosen channels. It can also convert one channel per start event, moving through the enabled channels. A start comes from a software pulse or, when allowed, from a timer pulse. A sticky completion flag and a one-cycle interrupt pulse mark the end of a conversion, or the end of a full pass in sweep modes. Continuous work stops when software removes the relevant channel enables, and the conversion in progress finishes first.

Top module: `sar_scan_seq`

## Requirements
- R1: After reset `busy`, `doneFlag`, `irq` and `shStrobe` are 0, `resultBus` is all zero, and `dacCode` is 8'h80.
- R2: With `modeSel`=0, a start converts channel `fixChan` once and then returns idle. `muxSel` holds that channel for the whole conversion. The code is written to `resultBus[8*c+7:8*c]` for channel c, and every other slot is left unchanged.
- R3: A conversion is one cycle with `shStrobe` high followed by eight bit cycles, from MSB to LSB. The first trial code is 8'h80. `cmpIn`=1 means the input is at or above `dacCode` and keeps the trial bit. The result and `doneFlag` appear 9 clocks after the clock edge that accepts the start.
- R4: Each completion event sets `doneFlag` and pulses `irq` high for exactly one cycle. Driving `doneClr` high clears `doneFlag`. A completion in the same cycle wins over the clear.
- R5: With `modeSel`=1, channel `fixChan` is converted again and again, with a completion after every conversion. When `chanEn[fixChan]` is cleared, the conversion in progress finishes and the block goes idle, keeping the last result.
- R6: With `modeSel`=2, every channel enabled in `chanEn` is converted once, in ascending index order. A single completion is raised at the end of the pass.
- R7: With `modeSel`=3, the ascending pass repeats without end, with one completion per pass. The block stops once `chanEn` is all zero at the end of a pass.
- R8: With `modeSel`=4, the block alternates `fixChan`, `altChan`, `fixChan`, ..., with a completion after every conversion. It stops when either of the two channels loses its enable.
- R9: With `modeSel`=5, each start converts exactly one channel: the lowest enabled index above the last one stepped, wrapping to the lowest enabled index. The first step after reset takes the lowest enabled channel.
- R10: A start is accepted from `swStart`, or from `timerTrig` when `trigEn` is 1. `timerTrig` has no effect while `trigEn` is 0.
- R11: A start does nothing when the channels the mode needs are not enabled: `chanEn[fixChan]` in modes 0 and 1, any bit in modes 2, 3 and 5, both chosen channels in mode 4. A start also does nothing for `modeSel` 6 or 7.
- R12: Start requests that arrive while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 3 | Sequencing mode, 0 to 5 |
| chanEn | input | 4 | Per-channel enable mask |
| fixChan | input | 2 | Fixed channel; first channel of the alternating pair |
| altChan | input | 2 | Second channel of the alternating pair |
| swStart | input | 1 | Software start pulse |
| trigEn | input | 1 | Allows timer starts |
| timerTrig | input | 1 | Timer start pulse |
| doneClr | input | 1 | Clears the completion flag |
| cmpIn | input | 1 | Comparator answer for the current trial code |
| muxSel | output | 2 | Analog selector code |
| shStrobe | output | 1 | Sample-and-hold strobe |
| dacCode | output | 8 | Trial code to the DAC |
| busy | output | 1 | Conversion or sequence running |
| doneFlag | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |
| resultBus | output | 32 | Four result slots, channel c at bits 8c+7..8c |

## Verification
A wrong search register or bit index shows at once on `dacCode`: the trial sequence for a known input strays from the binary search within one clock. Nine clocks later the stored code differs from the input value. A wrong channel pointer or continuation decision shows as an out-of-order or missing `muxSel` value at the next hold strobe, which is at most nine clocks after the previous conversion ends. It can also show as `busy` staying high after the enables are removed. A wrong completion decision shows as an `irq` count per pass that differs from one, or from one per conversion.

// File: rtl/sar_scan_pkg.sv
package sar_scan_pkg;

  typedef enum logic [2:0] {
    MODE_FIX_ONCE  = 3'd0,
    MODE_FIX_LOOP  = 3'd1,
    MODE_SCAN_ONCE = 3'd2,
    MODE_SCAN_LOOP = 3'd3,
    MODE_DUAL      = 3'd4,
    MODE_STEP      = 3'd5
  } scanMode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMP,
    ST_CONV
  } seqState_e;

  // strobes from the sequencer to the search datapath
  typedef struct packed {
    logic sample;
    logic step;
    logic commit;
  } dpCtl_t;

endpackage

// File: rtl/sar_scan_dp.sv
module sar_scan_dp
  import sar_scan_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int NUM_CH   = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpCtl_t                            ctl,
  input  logic [$clog2(NUM_CH)-1:0]         chSel,
  input  logic                              cmpIn,
  output logic [RES_BITS-1:0]               dacCode,
  output logic                              lastBit,
  output logic [NUM_CH*RES_BITS-1:0]        resultBus
);

  localparam int IDX_W = $clog2(RES_BITS);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_BITS - 1);

  logic [RES_BITS-1:0] acc;
  logic [RES_BITS-1:0] nxtAcc;
  logic [IDX_W-1:0]    bitIdx;

  assign dacCode = acc | (RES_BITS'(1) << bitIdx);
  assign nxtAcc  = cmpIn ? dacCode : acc;
  assign lastBit = (bitIdx == '0);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.sample) begin
      acc    <= '0;
      bitIdx <= TOP_IDX;
    end else if (ctl.step) begin
      acc    <= nxtAcc;
      bitIdx <= lastBit ? TOP_IDX : bitIdx - 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)
        resultBus[c*RES_BITS +: RES_BITS] <= '0;
      else if (ctl.commit && chSel == ($clog2(NUM_CH))'(c))
        resultBus[c*RES_BITS +: RES_BITS] <= nxtAcc;
    end
  end

endmodule

// File: rtl/sar_scan_ctrl.sv
module sar_scan_ctrl
  import sar_scan_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [2:0]                  modeSel,
  input  logic [NUM_CH-1:0]           chanEn,
  input  logic [$clog2(NUM_CH)-1:0]   fixChan,
  input  logic [$clog2(NUM_CH)-1:0]   altChan,
  input  logic                        swStart,
  input  logic                        trigEn,
  input  logic                        timerTrig,
  input  logic                        doneClr,
  input  logic                        lastBit,
  output dpCtl_t                      ctl,
  output logic [$clog2(NUM_CH)-1:0]   chSel,
  output logic                        busy,
  output logic                        doneFlag,
  output logic                        irq
);

  localparam int CH_W = $clog2(NUM_CH);

  seqState_e       state, stateN;
  scanMode_e       runMode, modeN;
  logic [CH_W-1:0] curCh, chN, partner, partN, stepPtr, ptrN;
  logic            doneEv, req;
  logic [CH_W:0]   firstHit, nextHit, stepHit;

  // lowest enabled channel strictly above 'from'; top bit flags a hit
  function automatic logic [CH_W:0] seekAbove(input logic [NUM_CH-1:0] mask, input int from);
    logic [CH_W:0] hit;
    hit = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (mask[i] && i > from) hit = {1'b1, CH_W'(i)};
    return hit;
  endfunction

  assign req      = swStart | (trigEn & timerTrig);
  assign firstHit = seekAbove(chanEn, -1);
  assign nextHit  = seekAbove(chanEn, int'(curCh));
  assign stepHit  = seekAbove(chanEn, int'(stepPtr));

  always_comb begin
    stateN = state;
    modeN  = runMode;
    chN    = curCh;
    partN  = partner;
    ptrN   = stepPtr;
    doneEv = 1'b0;
    unique case (state)
      ST_IDLE: if (req) begin
        case (modeSel)
          MODE_FIX_ONCE, MODE_FIX_LOOP: if (chanEn[fixChan]) begin
            stateN = ST_SAMP; chN = fixChan; modeN = scanMode_e'(modeSel);
          end
          MODE_SCAN_ONCE, MODE_SCAN_LOOP: if (firstHit[CH_W]) begin
            stateN = ST_SAMP; chN = firstHit[CH_W-1:0]; modeN = scanMode_e'(modeSel);
          end
          MODE_DUAL: if (chanEn[fixChan] && chanEn[altChan]) begin
            stateN = ST_SAMP; chN = fixChan; partN = altChan; modeN = MODE_DUAL;
          end
          MODE_STEP: if (firstHit[CH_W]) begin
            stateN = ST_SAMP; modeN = MODE_STEP;
            chN    = stepHit[CH_W] ? stepHit[CH_W-1:0] : firstHit[CH_W-1:0];
            ptrN   = chN;
          end
          default: ;
        endcase
      end
      ST_SAMP: stateN = ST_CONV;
      ST_CONV: if (lastBit) begin
        stateN = ST_IDLE;
        case (runMode)
          MODE_FIX_LOOP: begin
            doneEv = 1'b1;
            if (chanEn[curCh]) stateN = ST_SAMP;
          end
          MODE_DUAL: begin
            doneEv = 1'b1;
            if (chanEn[curCh] && chanEn[partner]) begin
              stateN = ST_SAMP; chN = partner; partN = curCh;
            end
          end
          MODE_SCAN_ONCE, MODE_SCAN_LOOP: begin
            if (nextHit[CH_W]) begin
              stateN = ST_SAMP; chN = nextHit[CH_W-1:0];
            end else begin
              doneEv = 1'b1;
              if (runMode == MODE_SCAN_LOOP && firstHit[CH_W]) begin
                stateN = ST_SAMP; chN = firstHit[CH_W-1:0];
              end
            end
          end
          default: doneEv = 1'b1;
        endcase
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      runMode  <= MODE_FIX_ONCE;
      curCh    <= '0;
      partner  <= '0;
      stepPtr  <= CH_W'(NUM_CH - 1);
      doneFlag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      state    <= stateN;
      runMode  <= modeN;
      curCh    <= chN;
      partner  <= partN;
      stepPtr  <= ptrN;
      irq      <= doneEv;
      if (doneEv)       doneFlag <= 1'b1;
      else if (doneClr) doneFlag <= 1'b0;
    end
  end

  assign ctl.sample = (state == ST_SAMP);
  assign ctl.step   = (state == ST_CONV);
  assign ctl.commit = (state == ST_CONV) && lastBit;
  assign chSel      = curCh;
  assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/sar_scan_seq.sv
module sar_scan_seq
  import sar_scan_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int NUM_CH   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [2:0]                  modeSel,
  input  logic [NUM_CH-1:0]           chanEn,
  input  logic [$clog2(NUM_CH)-1:0]   fixChan,
  input  logic [$clog2(NUM_CH)-1:0]   altChan,
  input  logic                        swStart,
  input  logic                        trigEn,
  input  logic                        timerTrig,
  input  logic                        doneClr,
  input  logic                        cmpIn,
  output logic [$clog2(NUM_CH)-1:0]   muxSel,
  output logic                        shStrobe,
  output logic [RES_BITS-1:0]         dacCode,
  output logic                        busy,
  output logic                        doneFlag,
  output logic                        irq,
  output logic [NUM_CH*RES_BITS-1:0]  resultBus
);

  dpCtl_t                      ctl;
  logic [$clog2(NUM_CH)-1:0]   chSel;
  logic                        lastBit;

  sar_scan_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .chanEn(chanEn),
    .fixChan(fixChan), .altChan(altChan), .swStart(swStart),
    .trigEn(trigEn), .timerTrig(timerTrig), .doneClr(doneClr),
    .lastBit(lastBit), .ctl(ctl), .chSel(chSel), .busy(busy),
    .doneFlag(doneFlag), .irq(irq)
  );

  sar_scan_dp #(.RES_BITS(RES_BITS), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .chSel(chSel), .cmpIn(cmpIn),
    .dacCode(dacCode), .lastBit(lastBit), .resultBus(resultBus)
  );

  assign muxSel   = chSel;
  assign shStrobe = ctl.sample;

endmodule

// File: rtl/sar_scan_chk.sv
module sar_scan_chk #(
  parameter int RES_BITS = 8,
  parameter int NUM_CH   = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      shStrobe,
  input logic                      busy,
  input logic [RES_BITS-1:0]       dacCode,
  input logic [$clog2(NUM_CH)-1:0] muxSel,
  input logic                      irq,
  input logic                      doneFlag,
  input logic                      doneClr,
  input logic [NUM_CH-1:0]         chanEn
);

  localparam logic [RES_BITS-1:0] MID_CODE = {1'b1, {(RES_BITS-1){1'b0}}};

  // R3
  msb_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    shStrobe |=> dacCode == MID_CODE);

  // R3
  sample_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    shStrobe |=> (!shStrobe && busy));

  // R2
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !shStrobe) |-> $stable(muxSel));

  // R4
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> doneFlag);

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> irq);

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && doneClr && !busy) |=> !doneFlag);

  // R11
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && chanEn == '0) |=> !busy);

endmodule

bind sar_scan_seq sar_scan_chk #(.RES_BITS(RES_BITS), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .shStrobe(shStrobe), .busy(busy), .dacCode(dacCode),
  .muxSel(muxSel), .irq(irq), .doneFlag(doneFlag), .doneClr(doneClr), .chanEn(chanEn)
);

// File: tb/sar_scan_seq_test.sv
module sar_scan_seq_test;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic [3:0] chanEn = 4'hF;
  logic [1:0] fixChan = 2'd0, altChan = 2'd0;
  logic       swStart = 1'b0, trigEn = 1'b0, timerTrig = 1'b0, doneClr = 1'b0;
  logic       cmpIn;
  logic [1:0] muxSel;
  logic       shStrobe, busy, doneFlag, irq;
  logic [7:0] dacCode;
  logic [31:0] resultBus;

  logic [7:0] vin [4];
  logic [7:0] expRes [4];
  logic [1:0] rec [256];
  int strobeTot = 0, irqTot = 0;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  // ideal comparator: high when the held input is at or above the trial code
  assign cmpIn = (vin[muxSel] >= dacCode);

  sar_scan_seq uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .chanEn(chanEn),
    .fixChan(fixChan), .altChan(altChan), .swStart(swStart),
    .trigEn(trigEn), .timerTrig(timerTrig), .doneClr(doneClr),
    .cmpIn(cmpIn), .muxSel(muxSel), .shStrobe(shStrobe), .dacCode(dacCode),
    .busy(busy), .doneFlag(doneFlag), .irq(irq), .resultBus(resultBus)
  );

  // values seen just before each edge
  always @(posedge clk) begin
    if (rstN && shStrobe) begin
      rec[strobeTot % 256] <= muxSel;
      strobeTot <= strobeTot + 1;
    end
    if (rstN && irq) irqTot <= irqTot + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] slot(input int c);
    return resultBus[c*8 +: 8];
  endfunction

  task automatic pulseStart();
    @(negedge clk) swStart = 1'b1;
    @(negedge clk) swStart = 1'b0;
  endtask

  task automatic clearDone();
    @(negedge clk) doneClr = 1'b1;
    @(negedge clk) doneClr = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic waitIrq(input int target);
    int n = 0;
    while (irqTot < target && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic checkAll(input string tag);
    for (int c = 0; c < 4; c++) check(slot(c) == expRes[c], tag, slot(c), expRes[c]);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sb, ib, lat, k;
    for (int c = 0; c < 4; c++) begin vin[c] = 8'h00; expRes[c] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1 reset values
    check(busy == 0 && doneFlag == 0 && irq == 0 && shStrobe == 0, "R1 idle outputs",
          {busy, doneFlag, irq, shStrobe}, 0);
    check(resultBus == 0, "R1 results cleared", resultBus, 0);
    check(dacCode == 8'h80, "R1 dac code", dacCode, 8'h80);
    @(negedge clk) rstN = 1'b1;

    // R2 R3 R4: every code, channel rotating, mode 0
    modeSel = 3'd0; chanEn = 4'hF;
    for (int v = 0; v < 256; v++) begin
      fixChan = 2'(v % 4);
      vin[v % 4] = 8'(v);
      for (int c = 0; c < 4; c++) if (c != v % 4) vin[c] = 8'(~v);
      sb = strobeTot;
      pulseStart();
      lat = 0;
      while (!doneFlag && lat < 40) begin @(negedge clk); lat++; end
      check(lat == 9, "R3 latency", lat, 9);
      check(irq == 1, "R4 irq with flag", irq, 1);
      check(busy == 0, "R2 idle after one", busy, 0);
      expRes[v % 4] = 8'(v);
      checkAll("R2 result slots");
      @(negedge clk);
      check(irq == 0, "R4 irq one cycle", irq, 0);
      check(strobeTot - sb == 1, "R2 single strobe", strobeTot - sb, 1);
      clearDone();
      check(doneFlag == 0, "R4 flag cleared", doneFlag, 1'b0);
    end

    // R12 restart while busy
    fixChan = 2'd2; vin[2] = 8'h5A; sb = strobeTot;
    pulseStart();
    repeat (3) @(negedge clk);
    swStart = 1'b1; @(negedge clk) swStart = 1'b0;
    waitIdle(); repeat (2) @(negedge clk);
    check(strobeTot - sb == 1, "R12 start ignored while busy", strobeTot - sb, 1);
    expRes[2] = 8'h5A; checkAll("R12 result");

    // R10 timer start
    fixChan = 2'd1; vin[1] = 8'hA7; sb = strobeTot; trigEn = 1'b0;
    @(negedge clk) timerTrig = 1'b1;
    @(negedge clk) timerTrig = 1'b0;
    repeat (2) @(negedge clk);
    check(busy == 0 && strobeTot == sb, "R10 timer masked", strobeTot - sb, 0);
    trigEn = 1'b1;
    @(negedge clk) timerTrig = 1'b1;
    @(negedge clk) timerTrig = 1'b0;
    waitIdle(); repeat (2) @(negedge clk);
    check(strobeTot - sb == 1, "R10 timer start", strobeTot - sb, 1);
    expRes[1] = 8'hA7; checkAll("R10 result");
    trigEn = 1'b0;

    // R11 starts that must do nothing
    sb = strobeTot;
    chanEn = 4'h0;
    for (int m = 0; m < 6; m++) begin modeSel = 3'(m); pulseStart(); repeat (2) @(negedge clk); end
    chanEn = 4'hF;
    for (int m = 6; m < 8; m++) begin modeSel = 3'(m); pulseStart(); repeat (2) @(negedge clk); end
    modeSel = 3'd4; fixChan = 2'd0; altChan = 2'd3; chanEn = 4'b0111;
    pulseStart(); repeat (2) @(negedge clk);
    modeSel = 3'd0; fixChan = 2'd3;
    pulseStart(); repeat (2) @(negedge clk);
    check(strobeTot == sb && busy == 0, "R11 no conversion", strobeTot - sb, 0);
    checkAll("R11 results untouched");

    // R6 one pass for every non-empty mask
    modeSel = 3'd2;
    for (int m = 1; m < 16; m++) begin
      chanEn = 4'(m);
      for (int c = 0; c < 4; c++) vin[c] = 8'((m * 16 + c * 37) & 8'hFF);
      sb = strobeTot; ib = irqTot;
      pulseStart(); waitIdle(); repeat (2) @(negedge clk);
      check(strobeTot - sb == $countones(4'(m)), "R6 conversion count", strobeTot - sb, $countones(4'(m)));
      check(irqTot - ib == 1, "R6 one completion per pass", irqTot - ib, 1);
      k = sb;
      for (int c = 0; c < 4; c++) if (m[c]) begin
        check(rec[k % 256] == 2'(c), "R6 ascending order", rec[k % 256], c);
        k++;
        expRes[c] = vin[c];
      end
      checkAll("R6 enabled slots only");
      clearDone();
    end

    // R9 single step, mask 1011: 0,1,3,0,1
    modeSel = 3'd5; chanEn = 4'b1011;
    for (int c = 0; c < 4; c++) vin[c] = 8'(8'h21 + c * 8'h30);
    for (int s = 0; s < 5; s++) begin
      int expCh;
      expCh = (s % 3 == 2) ? 3 : s % 3;
      sb = strobeTot;
      pulseStart(); waitIdle(); repeat (2) @(negedge clk);
      check(strobeTot - sb == 1, "R9 one per start", strobeTot - sb, 1);
      check(rec[sb % 256] == 2'(expCh), "R9 step channel", rec[sb % 256], expCh);
      expRes[expCh] = vin[expCh];
    end
    checkAll("R9 results");

    // R5 fixed channel continuous
    modeSel = 3'd1; chanEn = 4'hF; fixChan = 2'd1; vin[1] = 8'h3C;
    sb = strobeTot; ib = irqTot;
    pulseStart(); waitIrq(ib + 2);
    check(slot(1) == 8'h3C, "R5 repeated result", slot(1), 8'h3C);
    vin[1] = 8'hC3;
    waitIrq(ib + 4);
    check(slot(1) == 8'hC3, "R5 tracks input", slot(1), 8'hC3);
    chanEn = 4'b1101; ib = irqTot;
    waitIdle(); repeat (2) @(negedge clk);
    check(busy == 0 && irqTot - ib == 1, "R5 stops after current", irqTot - ib, 1);
    check(slot(1) == 8'hC3, "R5 result kept", slot(1), 8'hC3);
    for (int i = sb; i < strobeTot; i++) check(rec[i % 256] == 2'd1, "R5 channel", rec[i % 256], 1);
    clearDone();

    // R7 continuous pass over channels 0 and 2
    modeSel = 3'd3; chanEn = 4'b0101; sb = strobeTot; ib = irqTot;
    pulseStart(); waitIrq(ib + 2);
    for (int i = 0; i < 4; i++)
      check(rec[(sb + i) % 256] == 2'((i % 2) * 2), "R7 repeated pass", rec[(sb + i) % 256], (i % 2) * 2);
    chanEn = 4'b0000;
    waitIdle(); repeat (2) @(negedge clk);
    check(busy == 0, "R7 stops on empty mask", busy, 0);
    clearDone();

    // R8 alternating pair 3,1
    modeSel = 3'd4; chanEn = 4'hF; fixChan = 2'd3; altChan = 2'd1;
    vin[3] = 8'hE1; vin[1] = 8'h0F; sb = strobeTot; ib = irqTot;
    pulseStart(); waitIrq(ib + 4);
    for (int i = 0; i < 4; i++)
      check(rec[(sb + i) % 256] == ((i % 2 == 0) ? 2'd3 : 2'd1), "R8 alternation", rec[(sb + i) % 256], (i % 2 == 0) ? 3 : 1);
    chanEn = 4'b0111;
    waitIdle(); repeat (2) @(negedge clk);
    check(busy == 0, "R8 stops on lost enable", busy, 0);
    check(slot(3) == 8'hE1 && slot(1) == 8'h0F, "R8 results", {slot(3), slot(1)}, 16'hE10F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule